// File: doc/BRIEF.md
# Doubleword Store Unit

This unit executes the four 64-bit store instructions of a big-endian load/store architecture: displacement, displacement with update, indexed, and indexed with update. It takes one 32-bit instruction word at a time and decodes it. It reads the source, base and index values through three combinational register-file read ports, forms a 32-bit effective address and issues one or two byte-enabled memory write beats. For the update forms it then writes the effective address back into the base register.

Each store also produces a reservation-invalidate strobe that carries the effective address, so that an outstanding load-reserve on that address can be cancelled. Unaligned addresses are accepted. A store whose eight bytes run past a 128-byte line boundary is split into two beats, one per line. Encodings that name an update form with a zero base field are reported as invalid forms. Any word that is not one of the four stores is reported as unrecognised. Neither kind of word has any side effect.

The instruction side is a simple valid/busy pair: a word is taken in a cycle where `instValid` is high and `busy` is low. The memory and write-back sides each use a valid/ready handshake.

Top module: `dwstore_unit`

## Requirements
- R1: A word is a store only if bits 31:26 (big-endian bits 0–5) hold 62 with bits 1:0 equal to 0 (plain) or 1 (update), or if they hold 31 with bits 10:1 equal to 149 (plain indexed) or 181 (indexed update) and bit 0 clear. Any other accepted word pulses `unknownOp` for exactly the one cycle after acceptance, and produces no memory beat, no write-back and no reservation strobe.
- R2: In the displacement forms, bits 15:2 are a signed 14-bit field. It is sign-extended, shifted left by two and added to the base. The low 32 bits of the 64-bit sum form the effective address (EA).
- R3: In the two non-update forms, a base field (bits 20:16) of 0 uses the constant zero as the base, not register 0.
- R4: An update form with a base field of 0 pulses `invalidForm` for exactly the one cycle after acceptance, with no memory beat, write-back or reservation strobe.
- R5: Byte lane i of a beat covers address `memAddr`+i, with `memBe[i]` set and its data at `memData[8i+7:8i]`. Source byte k (k=0 is bits 63:56) is written to EA+k. Disabled lanes carry zero. A store that stays inside one 128-byte line is a single beat with `memAddr`=EA and `memBe`=8'hFF.
- R6: When EA mod 128 exceeds 120, the store is two beats. The first beat has `memAddr`=EA and enables the n = 128 − (EA mod 128) lowest lanes. The second beat follows it, has `memAddr`=EA+n (line-aligned), and carries source bytes n..7 in lanes 0..7−n.
- R7: Update forms issue the write-back after the last memory beat is accepted. The write-back targets the base register with data equal to EA zero-extended to 64 bits. The stored data is the source value read at acceptance, even when the source and base fields name the same register.
- R8: `resvInval` is high exactly in the cycle where a store's first beat is accepted, and only if `resvEnable` and `resvActive` are both high. In that cycle `resvAddr` equals EA.
- R9: After reset the unit is idle with no request outstanding. A memory request holds until `memReady`. `busy` stays high from acceptance until the last beat or the write-back is accepted. Words presented while busy are ignored.
- R10: In the indexed forms, EA is the low 32 bits of the base plus the index-register value (bits 15:11). The base follows the same zero rule as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word presented |
| instWord | input | 32 | Instruction word |
| busy | output | 1 | Unit is executing a store; new words are ignored |
| rdIdxS | output | 5 | Read port index for the source register |
| rdIdxA | output | 5 | Read port index for the base register |
| rdIdxB | output | 5 | Read port index for the index register |
| rdDataS | input | 64 | Source register value |
| rdDataA | input | 64 | Base register value |
| rdDataB | input | 64 | Index register value |
| memValid | output | 1 | Memory write beat valid |
| memReady | input | 1 | Memory accepts the beat |
| memAddr | output | 32 | Byte address of lane 0 |
| memBe | output | 8 | Lane enables |
| memData | output | 64 | Lane data |
| wbValid | output | 1 | Register write-back valid |
| wbReady | input | 1 | Register file accepts the write-back |
| wbIdx | output | 5 | Write-back register index |
| wbData | output | 64 | Write-back value |
| resvEnable | input | 1 | Reservation tracking enabled |
| resvActive | input | 1 | A reservation is currently held |
| resvInval | output | 1 | Reservation-invalidate strobe |
| resvAddr | output | 32 | Address carried by the strobe |
| invalidForm | output | 1 | Invalid update-form pulse |
| unknownOp | output | 1 | Unrecognised word pulse |

## Verification
The reservation-invalidate strobe and the acceptance of the first memory beat must fall in the same cycle. A second beat or a write-back that follows must not repeat the strobe. The bench drives `memReady` and `wbReady` from a pseudo-random pattern, so the first beat is often held for several cycles. It also runs the enable and active inputs through all four combinations. Each cycle, the reference model predicts whether the strobe is due, from its own queue of expected beats and the ready value it drove. The bench also keeps offering instruction words while the unit is busy, to show that acceptance and execution never overlap.

// File: rtl/dws_pkg.sv
package dws_pkg;

  localparam logic [5:0] OPC_DISP  = 6'd62;
  localparam logic [5:0] OPC_XFORM = 6'd31;
  localparam logic [9:0] XO_INDEX  = 10'd149;
  localparam logic [9:0] XO_INDEXU = 10'd181;
  localparam int         DISP_W    = 14;

  typedef enum logic [2:0] {
    K_DISP,
    K_DISPU,
    K_IDX,
    K_IDXU,
    K_BADFORM,
    K_UNKNOWN
  } storeKind_t;

  typedef struct packed {
    logic capture;
    logic beatActive;
    logic secondBeat;
  } dpCtrl_t;

endpackage

// File: rtl/dws_dp.sv
module dws_dp
  import dws_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 128,
  parameter int IDX_W      = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [31:0]           instWord,
  input  logic [DATA_W-1:0]     rdDataS,
  input  logic [DATA_W-1:0]     rdDataA,
  input  logic [DATA_W-1:0]     rdDataB,
  input  dpCtrl_t               ctl,
  output storeKind_t            kind,
  output logic [IDX_W-1:0]      rdIdxS,
  output logic [IDX_W-1:0]      rdIdxA,
  output logic [IDX_W-1:0]      rdIdxB,
  output logic                  straddle,
  output logic [ADDR_W-1:0]     eaOut,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W/8-1:0]   memBe,
  output logic [DATA_W-1:0]     memData,
  output logic [IDX_W-1:0]      wbIdx,
  output logic [DATA_W-1:0]     wbData
);

  localparam int BYTES    = DATA_W / 8;
  localparam int CNT_W    = $clog2(BYTES) + 1;
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam logic [CNT_W-1:0]  BYTES_C = CNT_W'(BYTES);
  localparam logic [LINE_LSB:0] LINE_SZ = (LINE_LSB+1)'(LINE_BYTES);
  localparam logic [LINE_LSB:0] BYTES_L = (LINE_LSB+1)'(BYTES);

  // instruction fields (big-endian bit 0 is instWord[31])
  logic [5:0]        opcF;
  logic [IDX_W-1:0]  rsF, raF, rbF;
  logic [DISP_W-1:0] dispF;
  logic [1:0]        dsXoF;
  logic [9:0]        xXoF;
  logic              rcF;

  assign opcF  = instWord[31:26];
  assign rsF   = instWord[25:21];
  assign raF   = instWord[20:16];
  assign rbF   = instWord[15:11];
  assign dispF = instWord[15:2];
  assign dsXoF = instWord[1:0];
  assign xXoF  = instWord[10:1];
  assign rcF   = instWord[0];

  assign rdIdxS = rsF;
  assign rdIdxA = raF;
  assign rdIdxB = rbF;

  always_comb begin
    kind = K_UNKNOWN;
    if (opcF == OPC_DISP) begin
      if (dsXoF == 2'd0)      kind = K_DISP;
      else if (dsXoF == 2'd1) kind = (raF == '0) ? K_BADFORM : K_DISPU;
    end else if (opcF == OPC_XFORM && !rcF) begin
      if (xXoF == XO_INDEX)       kind = K_IDX;
      else if (xXoF == XO_INDEXU) kind = (raF == '0) ? K_BADFORM : K_IDXU;
    end
  end

  // address generation
  logic              zeroBase, indexed;
  logic [DATA_W-1:0] baseVal, offsetVal, sumVal;
  logic [ADDR_W-1:0] eaNext;
  logic [LINE_LSB:0] room;
  logic              straddleNext;
  logic [CNT_W-1:0]  firstCntNext;

  assign zeroBase  = (raF == '0) && (kind == K_DISP || kind == K_IDX);
  assign indexed   = (kind == K_IDX) || (kind == K_IDXU);
  assign baseVal   = zeroBase ? '0 : rdDataA;
  assign offsetVal = indexed ? rdDataB
                   : {{(DATA_W-DISP_W-2){dispF[DISP_W-1]}}, dispF, 2'b00};
  assign sumVal    = baseVal + offsetVal;
  assign eaNext    = sumVal[ADDR_W-1:0];

  assign room         = LINE_SZ - {1'b0, eaNext[LINE_LSB-1:0]};
  assign straddleNext = room < BYTES_L;
  assign firstCntNext = straddleNext ? room[CNT_W-1:0] : BYTES_C;

  logic [ADDR_W-1:0] eaQ;
  logic [DATA_W-1:0] srcQ;
  logic [IDX_W-1:0]  baseIdxQ;
  logic              straddleQ;
  logic [CNT_W-1:0]  firstCntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaQ       <= '0;
      srcQ      <= '0;
      baseIdxQ  <= '0;
      straddleQ <= 1'b0;
      firstCntQ <= '0;
    end else if (ctl.capture) begin
      eaQ       <= eaNext;
      srcQ      <= rdDataS;
      baseIdxQ  <= raF;
      straddleQ <= straddleNext;
      firstCntQ <= firstCntNext;
    end
  end

  // beat formation: lane i holds source byte (startByte + i)
  logic [CNT_W-1:0]  startByte, beatCnt;
  logic [DATA_W-1:0] shifted;

  assign startByte = ctl.secondBeat ? firstCntQ : '0;
  assign beatCnt   = ctl.secondBeat ? (BYTES_C - firstCntQ) : firstCntQ;
  assign shifted   = srcQ << {startByte, 3'b000};
  assign memAddr   = eaQ + {{(ADDR_W-CNT_W){1'b0}}, startByte};

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign memBe[i]       = CNT_W'(i) < beatCnt;
    assign memData[8*i+:8] = memBe[i] ? shifted[DATA_W-1-8*i -: 8] : 8'h00;
  end

  assign straddle = straddleQ;
  assign eaOut    = eaQ;
  assign wbIdx    = baseIdxQ;
  assign wbData   = {{(DATA_W-ADDR_W){1'b0}}, eaQ};

  // R6
  line_fit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.beatActive |-> (int'(memAddr[LINE_LSB-1:0]) + $countones(memBe) <= LINE_BYTES));

  // R6
  second_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.secondBeat |-> (memAddr[LINE_LSB-1:0] == '0));

endmodule

// File: rtl/dws_ctrl.sv
module dws_ctrl
  import dws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  storeKind_t kind,
  input  logic       straddle,
  input  logic       memReady,
  input  logic       wbReady,
  input  logic       resvEnable,
  input  logic       resvActive,
  output logic       busy,
  output logic       memValid,
  output logic       wbValid,
  output logic       resvInval,
  output logic       invalidForm,
  output logic       unknownOp,
  output dpCtrl_t    ctl
);

  typedef enum logic [1:0] {S_IDLE, S_BEAT1, S_BEAT2, S_WB} state_t;

  state_t state;
  logic   updQ;
  logic   accept;

  assign accept = instValid && (state == S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      updQ        <= 1'b0;
      invalidForm <= 1'b0;
      unknownOp   <= 1'b0;
    end else begin
      invalidForm <= 1'b0;
      unknownOp   <= 1'b0;
      case (state)
        S_IDLE: if (instValid) begin
          if (kind == K_BADFORM)      invalidForm <= 1'b1;
          else if (kind == K_UNKNOWN) unknownOp   <= 1'b1;
          else begin
            state <= S_BEAT1;
            updQ  <= (kind == K_DISPU) || (kind == K_IDXU);
          end
        end
        S_BEAT1: if (memReady) begin
          if (straddle)  state <= S_BEAT2;
          else if (updQ) state <= S_WB;
          else           state <= S_IDLE;
        end
        S_BEAT2: if (memReady) state <= updQ ? S_WB : S_IDLE;
        S_WB:    if (wbReady)  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign memValid  = (state == S_BEAT1) || (state == S_BEAT2);
  assign wbValid   = (state == S_WB);
  assign resvInval = (state == S_BEAT1) && memReady && resvEnable && resvActive;

  assign ctl.capture    = accept;
  assign ctl.beatActive = memValid;
  assign ctl.secondBeat = (state == S_BEAT2);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid);

  // R9
  mem_wb_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memValid && wbValid));

  // R7
  wb_after_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbValid) |-> $past(memValid && memReady));

  // R8
  resv_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resvInval |=> !resvInval);

  // R1
  flag_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invalidForm || unknownOp) |-> (!busy && !(invalidForm && unknownOp)));

endmodule

// File: rtl/dwstore_unit.sv
module dwstore_unit
  import dws_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 128,
  parameter int IDX_W      = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [31:0]         instWord,
  output logic                busy,
  output logic [IDX_W-1:0]    rdIdxS,
  output logic [IDX_W-1:0]    rdIdxA,
  output logic [IDX_W-1:0]    rdIdxB,
  input  logic [DATA_W-1:0]   rdDataS,
  input  logic [DATA_W-1:0]   rdDataA,
  input  logic [DATA_W-1:0]   rdDataB,
  output logic                memValid,
  input  logic                memReady,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memBe,
  output logic [DATA_W-1:0]   memData,
  output logic                wbValid,
  input  logic                wbReady,
  output logic [IDX_W-1:0]    wbIdx,
  output logic [DATA_W-1:0]   wbData,
  input  logic                resvEnable,
  input  logic                resvActive,
  output logic                resvInval,
  output logic [ADDR_W-1:0]   resvAddr,
  output logic                invalidForm,
  output logic                unknownOp
);

  storeKind_t kind;
  dpCtrl_t    ctl;
  logic       straddle;

  dws_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .instWord(instWord),
    .rdDataS(rdDataS), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .ctl(ctl), .kind(kind),
    .rdIdxS(rdIdxS), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .straddle(straddle), .eaOut(resvAddr),
    .memAddr(memAddr), .memBe(memBe), .memData(memData),
    .wbIdx(wbIdx), .wbData(wbData)
  );

  dws_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .kind(kind),
    .straddle(straddle), .memReady(memReady), .wbReady(wbReady),
    .resvEnable(resvEnable), .resvActive(resvActive),
    .busy(busy), .memValid(memValid), .wbValid(wbValid),
    .resvInval(resvInval), .invalidForm(invalidForm),
    .unknownOp(unknownOp), .ctl(ctl)
  );

endmodule

// File: tb/dwstore_unit_tb.sv
module dwstore_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        busy;
  logic [4:0]  rdIdxS, rdIdxA, rdIdxB;
  logic [63:0] rdDataS, rdDataA, rdDataB;
  logic        memValid, memReady = 1'b0;
  logic [31:0] memAddr;
  logic [7:0]  memBe;
  logic [63:0] memData;
  logic        wbValid, wbReady = 1'b0;
  logic [4:0]  wbIdx;
  logic [63:0] wbData;
  logic        resvEnable = 1'b0, resvActive = 1'b0;
  logic        resvInval;
  logic [31:0] resvAddr;
  logic        invalidForm, unknownOp;

  always #5 clk = ~clk;

  dwstore_unit u_dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .busy(busy), .rdIdxS(rdIdxS), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .rdDataS(rdDataS), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memBe(memBe), .memData(memData), .wbValid(wbValid), .wbReady(wbReady),
    .wbIdx(wbIdx), .wbData(wbData), .resvEnable(resvEnable),
    .resvActive(resvActive), .resvInval(resvInval), .resvAddr(resvAddr),
    .invalidForm(invalidForm), .unknownOp(unknownOp)
  );

  // register file emulation
  logic [63:0] gpr [32];
  always_comb begin
    rdDataS = gpr[rdIdxS];
    rdDataA = gpr[rdIdxA];
    rdDataB = gpr[rdIdxB];
  end

  typedef struct {
    bit          isWb;
    bit          first;
    logic [31:0] addr;
    logic [7:0]  be;
    logic [63:0] data;
    logic [4:0]  idx;
  } item_t;

  item_t q[$];
  int    nChk = 0, nFail = 0, cycles = 0;
  bit    wdHit = 0, issuePending = 0, noise = 0, fast = 0;
  logic [31:0] pendWord = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit    expInv = 0, expUnk = 0;
  string curTag = "R2";

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic item_t mkBeat(logic [31:0] a, logic [63:0] src, int startB, int cnt, bit first);
    item_t it;
    it.isWb = 0; it.first = first; it.addr = a; it.be = '0; it.data = '0; it.idx = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < cnt) begin
        it.be[i] = 1'b1;
        it.data[8*i+:8] = src[63-8*(startB+i) -: 8];
      end
    end
    return it;
  endfunction

  task automatic modelAccept(logic [31:0] w);
    int opc, ra, rb, rs, xo2, xo10, rc, room;
    bit isSt, upd, idx;
    logic [63:0] base, off, src;
    logic [31:0] ea;
    item_t wb;
    opc = int'(w[31:26]); rs = int'(w[25:21]); ra = int'(w[20:16]); rb = int'(w[15:11]);
    xo2 = int'(w[1:0]); xo10 = int'(w[10:1]); rc = int'(w[0]);
    isSt = 0; upd = 0; idx = 0;
    if (opc == 62 && xo2 < 2) begin isSt = 1; upd = (xo2 == 1); end
    if (opc == 31 && rc == 0 && (xo10 == 149 || xo10 == 181)) begin
      isSt = 1; idx = 1; upd = (xo10 == 181);
    end
    if (!isSt) begin expUnk = 1; return; end
    if (upd && ra == 0) begin expInv = 1; return; end
    base = (ra == 0) ? 64'd0 : gpr[ra];
    off  = idx ? gpr[rb] : {{48{w[15]}}, w[15:2], 2'b00};
    ea   = 32'((base + off) & 64'hFFFF_FFFF);
    src  = gpr[rs];
    room = 128 - int'(ea % 128);
    if (room >= 8) q.push_back(mkBeat(ea, src, 0, 8, 1));
    else begin
      q.push_back(mkBeat(ea, src, 0, room, 1));
      q.push_back(mkBeat(ea + 32'(room), src, room, 8 - room, 0));
    end
    if (upd) begin
      wb.isWb = 1; wb.first = 0; wb.addr = ea; wb.be = '0;
      wb.data = {32'd0, ea}; wb.idx = 5'(ra);
      q.push_back(wb);
    end
  endtask

  task automatic step();
    bit expMem, expWb, expResv;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReady = lfsr[0] | fast;
    wbReady  = lfsr[3] | fast;
    if (issuePending) begin
      instValid = 1'b1; instWord = pendWord;
    end else if (q.size() > 0 && noise) begin
      instValid = 1'b1; instWord = 32'hFFFF_FFFF;
    end else begin
      instValid = 1'b0;
    end
    #1;
    expMem = (q.size() > 0) && !q[0].isWb;
    expWb  = (q.size() > 0) && q[0].isWb;
    chk("R9 busy", 64'(busy), 64'(q.size() > 0));
    chk("R9 memValid", 64'(memValid), 64'(expMem));
    chk("R7 wbValid", 64'(wbValid), 64'(expWb));
    if (expMem) begin
      chk({curTag, " memAddr"}, 64'(memAddr), 64'(q[0].addr));
      chk("R6 memBe", 64'(memBe), 64'(q[0].be));
      chk("R5 memData", memData, q[0].data);
    end
    if (expWb) begin
      chk("R7 wbIdx", 64'(wbIdx), 64'(q[0].idx));
      chk("R7 wbData", wbData, q[0].data);
    end
    expResv = expMem && q[0].first && memReady && resvEnable && resvActive;
    chk("R8 resvInval", 64'(resvInval), 64'(expResv));
    if (expResv) chk("R8 resvAddr", 64'(resvAddr), 64'(q[0].addr));
    chk("R4 invalidForm", 64'(invalidForm), 64'(expInv));
    chk("R1 unknownOp", 64'(unknownOp), 64'(expUnk));
    @(posedge clk);
    expInv = 0; expUnk = 0;
    if (q.size() > 0) begin
      if (!q[0].isWb && memReady) void'(q.pop_front());
      else if (q[0].isWb && wbReady) begin
        gpr[q[0].idx] = q[0].data;
        void'(q.pop_front());
      end
    end else if (issuePending) begin
      issuePending = 0;
      modelAccept(pendWord);
    end
    cycles++;
    if (cycles > 100000 && !wdHit) begin
      wdHit = 1; nChk++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
  endtask

  task automatic runInst(logic [31:0] w, string tag, bit en, bit act);
    if (wdHit) return;
    curTag = tag; resvEnable = en; resvActive = act;
    pendWord = w; issuePending = 1;
    while ((issuePending || q.size() > 0) && !wdHit) step();
    if (!wdHit) step();
  endtask

  function automatic logic [31:0] encD(int rs, int ra, int ds, int xo);
    logic [13:0] d = 14'(ds);
    return {6'd62, 5'(rs), 5'(ra), d, 2'(xo)};
  endfunction

  function automatic logic [31:0] encX(int rs, int ra, int rb, int xo, int rc);
    return {6'd31, 5'(rs), 5'(ra), 5'(rb), 10'(xo), 1'(rc)};
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) gpr[i] = {32'(i) * 32'h0101_0101, 32'hC0DE_0000 | 32'(i)};
    gpr[1]  = 64'h0000_0000_0000_1000;
    gpr[2]  = 64'h0123_4567_89AB_CDEF;
    gpr[3]  = 64'hFFFF_FFFF_FFFF_FFF8;
    gpr[5]  = 64'h0000_0000_0000_0240;
    gpr[6]  = 64'hAAAA_BBBB_0000_0100;
    gpr[7]  = 64'h0000_0001_FFFF_FFF0;
    gpr[8]  = 64'h0000_0000_0000_0020;
    gpr[9]  = 64'h0000_0000_0000_207C;
    gpr[10] = 64'h0000_0000_0000_307F;
    gpr[11] = 64'h0000_0000_0000_4079;
    gpr[12] = 64'h0000_0000_0000_5078;
    gpr[13] = 64'h0000_0000_0000_6003;
    gpr[14] = 64'h0000_0000_0000_7000;
    gpr[15] = 64'h0000_0000_0000_007E;

    // reset state, R9
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset busy", 64'(busy), 64'd0);
    chk("R9 reset memValid", 64'(memValid), 64'd0);
    chk("R9 reset wbValid", 64'(wbValid), 64'd0);
    chk("R1 reset flags", 64'({invalidForm, unknownOp, resvInval}), 64'd0);
    rstN = 1'b1;

    fast = 1;
    runInst(encD(2, 1, 4, 0),  "R2", 1, 1);   // positive displacement
    runInst(encD(2, 1, -2, 0), "R2", 1, 1);   // negative displacement
    runInst(encD(2, 0, 8, 0),  "R3", 1, 1);   // zero base, displacement
    fast = 0;
    runInst(encX(2, 0, 5, 149, 0), "R3", 1, 1);  // zero base, indexed
    runInst(encX(2, 1, 3, 149, 0), "R10", 0, 1); // indexed, negative index
    noise = 1;
    runInst(encD(2, 1, 2, 1), "R7", 1, 0);       // update form
    runInst(encD(6, 6, 0, 1), "R7", 1, 1);       // source equals base, truncation
    runInst(encX(2, 7, 8, 181, 0), "R10", 1, 1); // indexed update wrapping 32 bits
    runInst(encD(2, 9, 0, 0),  "R6", 1, 1);      // split 4/4
    runInst(encD(2, 10, 0, 0), "R6", 1, 1);      // split 1/7
    runInst(encD(2, 11, 0, 0), "R6", 0, 0);      // split 7/1
    runInst(encD(2, 12, 0, 0), "R6", 1, 1);      // ends exactly at line end
    runInst(encD(2, 13, 0, 0), "R5", 1, 1);      // unaligned, one beat
    runInst(encX(2, 14, 15, 181, 0), "R6", 1, 1);// split plus write-back
    noise = 0;
    runInst(encD(2, 0, 2, 1), "R4", 1, 1);       // update with zero base
    runInst(encX(2, 0, 1, 181, 0), "R4", 1, 1);
    runInst(encD(2, 1, 4, 2), "R1", 1, 1);       // unknown variants
    runInst(encD(2, 1, 4, 3), "R1", 1, 1);
    runInst(encX(2, 1, 3, 150, 0), "R1", 1, 1);
    runInst(encX(2, 1, 3, 149, 1), "R1", 1, 1);
    runInst(32'h3800_0000, "R1", 1, 1);
    runInst(encD(2, 1, 4, 0), "R2", 1, 1);       // unit still works afterwards
    for (int k = 0; k < 6; k++)
      runInst(encX(2, 1, 13, (k % 2 == 0) ? 149 : 181, 0), "R10", k[0], k[1]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule